// File: doc/BRIEF.md
# Receive Queue Read-Side Controller

This block keeps the read side of a circular receive queue. Each queue entry is the index of a message buffer. The indices occupy a window of slots that starts at a programmable start index and spans a programmable depth. One instance serves one receive channel.

The receive path pushes entries into the queue. Software removes the oldest entries through one of two pop styles, chosen by a mode input:
- **Count mode:** software gives a pop count. The block removes that many entries, limited to the number of entries actually present.
- **Flag mode:** each write of 1 to the channel's interrupt flag removes a single entry.

The block reports the fill level and the read index of the oldest valid entry. It also reports the write index where the next pushed entry will land. When the fill level is zero, the read index carries no valid entry and must not be used to fetch data.

The start index and depth must stay fixed while the controller is out of reset. The window must also fit inside the index range, so start plus depth is at most 2^IDX_W.

Top module: `rxq_pop_ctrl`

## Requirements
- R1: After reset, fill_lvl is 0, rd_idx and wr_idx both equal cfg_start, and ovf_pulse is 0.
- R2: With cfg_count_mode = 1, a cycle with pop_cnt_vld = 1 and a nonzero pop_cnt removes min(pop_cnt, fill_lvl) entries. A pop_cnt of 0 changes nothing.
- R3: A pop count larger than the fill level empties the queue, gives no error indication, and does not make fill_lvl wrap below zero.
- R4: rd_idx advances by exactly the number of entries removed, modulo the window. Past slot cfg_start + cfg_depth − 1 it continues from cfg_start, not from 0, including when one pop crosses the end of the window.
- R5: With cfg_count_mode = 0, a cycle with flag_clr = 1 removes exactly one entry when the queue is not empty.
- R6: In flag mode, flag_clr on an empty queue is ignored: fill_lvl stays 0, rd_idx is unchanged, and no indication is raised.
- R7: pop_cnt_vld has no effect while cfg_count_mode = 0, and flag_clr has no effect while cfg_count_mode = 1.
- R8: A push with fill_lvl below cfg_depth raises fill_lvl by one and advances wr_idx by one, wrapping to cfg_start at the end of the window.
- R9: A push and a pop in the same cycle change fill_lvl by the net amount, and both indices move by their own amounts.
- R10: A push when fill_lvl equals cfg_depth is rejected. fill_lvl and wr_idx stay unchanged, and ovf_pulse is 1 for exactly the next cycle.
- R11: All outputs change only on the clock edge that follows the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | IDX_W | First slot of the window |
| cfg_depth | input | IDX_W+1 | Number of slots in the window, 1 to 2^IDX_W |
| cfg_count_mode | input | 1 | 1 = pop by count, 0 = pop by flag clear |
| push | input | 1 | Receive path appends one entry |
| pop_cnt_vld | input | 1 | Qualifies pop_cnt for one cycle |
| pop_cnt | input | IDX_W+1 | Number of entries to remove |
| flag_clr | input | 1 | Software writes 1 to the channel interrupt flag |
| fill_lvl | output | IDX_W+1 | Number of valid entries |
| rd_idx | output | IDX_W | Slot of the oldest valid entry |
| wr_idx | output | IDX_W | Slot the next push writes |
| ovf_pulse | output | 1 | One-cycle pulse for a rejected push |

## Verification
The bench runs a behavioural reference model and compares all four outputs on every cycle. This exposes a design that wraps an index to zero instead of to the start index (R4), or that loses the wrap when one pop jumps across the window end (R4).

Over-sized pop counts and flag pops on an empty queue are driven explicitly (R3, R6). A design without saturation would underflow fill_lvl, and one that ignores emptiness would move rd_idx.

Each pop style is also driven while the other mode is selected (R7), which catches a missing mode gate. Pushes are made at full depth, both with and without a simultaneous pop (R10, R9). These catch a queue that overwrites its oldest entry, or an overflow pulse that lasts too long or never appears.

Three window configurations are run, including a full power-of-two window.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic {
    POP_BY_FLAG  = 1'b0,
    POP_BY_COUNT = 1'b1
  } pop_mode_e;
endpackage

// File: rtl/rxq_pop_sel.sv
// Turns the software pop request into the number of entries actually removed.
module rxq_pop_sel
  import rxq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pop_mode_e        mode,
  input  logic             cnt_vld,
  input  logic [CNT_W-1:0] cnt,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] fill,
  output logic [CNT_W-1:0] removed
);
  logic [CNT_W-1:0] req;

  always_comb begin
    req = '0;
    if (mode == POP_BY_COUNT) begin
      if (cnt_vld) req = cnt;
    end else begin
      if (flag_clr) req = CNT_W'(1);
    end
    removed = (req > fill) ? fill : req;
  end

  // R3: the amount removed never exceeds what the queue holds
  a_r3_pop_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    removed <= fill);

  // R7: a count request is inert in flag mode
  a_r7_count_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == POP_BY_FLAG && !flag_clr) |-> removed == '0);
endmodule

// File: rtl/rxq_ring_ptr.sv
// Offset pointer inside the window; the offset wraps modulo the window depth.
module rxq_ring_ptr #(
  parameter int IDX_W = 5,
  parameter int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] start,
  input  logic [CNT_W-1:0] depth,
  input  logic [CNT_W-1:0] step,
  output logic [IDX_W-1:0] idx
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] off_q, off_d;
  logic [SUM_W-1:0] sum;
  logic             adv_en;

  assign adv_en = (step != '0);

  always_comb begin
    sum   = {1'b0, off_q} + {1'b0, step};
    off_d = off_q;
    if (adv_en) begin
      if (sum >= {1'b0, depth}) off_d = CNT_W'(sum - {1'b0, depth});
      else                       off_d = sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (adv_en) off_q <= off_d;
  end

  assign idx = start + off_q[IDX_W-1:0];

  // R4: the offset always stays inside the window
  a_r4_offset_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    off_q < depth);

  // R4: the pointer holds when nothing is consumed
  a_r4_hold_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |=> $stable(off_q));
endmodule

// File: rtl/rxq_level.sv
// Fill-level counter, push acceptance and overflow pulse.
module rxq_level #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] depth,
  input  logic             push,
  input  logic [CNT_W-1:0] removed,
  output logic             push_ok,
  output logic [CNT_W-1:0] fill,
  output logic             ovf
);
  logic [CNT_W-1:0] fill_q, fill_d;
  logic             ovf_q, ovf_d;
  logic             full;
  logic             fill_en;

  assign full    = (fill_q == depth);
  assign push_ok = push && !full;
  assign fill_en = push_ok || (removed != '0);

  always_comb begin
    fill_d = fill_q - removed + CNT_W'(push_ok);
    ovf_d  = push && full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (fill_en) fill_q <= fill_d;
      ovf_q <= ovf_d;
    end
  end

  assign fill = fill_q;
  assign ovf  = ovf_q;

  // R10: the fill level never exceeds the depth
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= depth);

  // R10: the pulse only follows a push against a full queue
  a_r10_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> $past(push) && $past(fill_q) == depth);

  // R10: the pulse lasts a single cycle unless pushes keep hitting a full queue
  a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(push && full)) |=> !ovf_q);
endmodule

// File: rtl/rxq_pop_ctrl.sv
module rxq_pop_ctrl
  import rxq_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cfg_start,
  input  logic [IDX_W:0]   cfg_depth,
  input  logic             cfg_count_mode,
  input  logic             push,
  input  logic             pop_cnt_vld,
  input  logic [IDX_W:0]   pop_cnt,
  input  logic             flag_clr,
  output logic [IDX_W:0]   fill_lvl,
  output logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] wr_idx,
  output logic             ovf_pulse
);
  localparam int CNT_W = IDX_W + 1;

  pop_mode_e        mode;
  logic [CNT_W-1:0] removed;
  logic             push_ok;
  logic [CNT_W-1:0] push_step;

  assign mode      = cfg_count_mode ? POP_BY_COUNT : POP_BY_FLAG;
  assign push_step = CNT_W'(push_ok);

  rxq_pop_sel #(.CNT_W(CNT_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .cnt_vld  (pop_cnt_vld),
    .cnt      (pop_cnt),
    .flag_clr (flag_clr),
    .fill     (fill_lvl),
    .removed  (removed)
  );

  rxq_level #(.CNT_W(CNT_W)) u_lvl (
    .clk     (clk),
    .rst_n   (rst_n),
    .depth   (cfg_depth),
    .push    (push),
    .removed (removed),
    .push_ok (push_ok),
    .fill    (fill_lvl),
    .ovf     (ovf_pulse)
  );

  rxq_ring_ptr #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cfg_start),
    .depth (cfg_depth),
    .step  (removed),
    .idx   (rd_idx)
  );

  rxq_ring_ptr #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_wr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cfg_start),
    .depth (cfg_depth),
    .step  (push_step),
    .idx   (wr_idx)
  );

  // R6: a flag pop on an empty queue leaves everything alone
  a_r6_empty_flag_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_count_mode && flag_clr && fill_lvl == '0 && !push)
      |=> $stable(rd_idx) && fill_lvl == '0);

  // R5: a flag pop on a non-empty queue takes exactly one entry
  a_r5_flag_pops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_count_mode && flag_clr && fill_lvl != '0 && !push)
      |=> fill_lvl == $past(fill_lvl) - 1'b1);
endmodule

// File: tb/tb_rxq_pop_ctrl.sv
module tb_rxq_pop_ctrl;
  localparam int IDX_W  = 5;
  localparam int CLK_NS = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [IDX_W-1:0] cfg_start;
  logic [IDX_W:0]   cfg_depth;
  logic             cfg_count_mode;
  logic             push;
  logic             pop_cnt_vld;
  logic [IDX_W:0]   pop_cnt;
  logic             flag_clr;
  logic [IDX_W:0]   fill_lvl;
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  logic             ovf_pulse;

  rxq_pop_ctrl #(.IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_depth(cfg_depth),
    .cfg_count_mode(cfg_count_mode), .push(push), .pop_cnt_vld(pop_cnt_vld),
    .pop_cnt(pop_cnt), .flag_clr(flag_clr), .fill_lvl(fill_lvl),
    .rd_idx(rd_idx), .wr_idx(wr_idx), .ovf_pulse(ovf_pulse)
  );

  always #(CLK_NS/2) clk = ~clk;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string tag   = "R1";

  // reference model state
  int m_fill, m_rd, m_wr, m_start, m_depth;
  bit m_ovf;

  task automatic cmp(string what, int act, int exp);
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare outputs (mid-cycle) against the model
  task automatic check_all();
    n_vec++;
    cmp("fill_lvl", int'(fill_lvl), m_fill);
    cmp("rd_idx", int'(rd_idx), m_start + m_rd);
    cmp("wr_idx", int'(wr_idx), m_start + m_wr);
    cmp("ovf_pulse", int'(ovf_pulse), int'(m_ovf));
  endtask

  // drive one cycle of stimulus at a falling edge, advance the model
  task automatic cyc(bit mode, bit p, bit cv, int c, bit f);
    int req, rem;
    bit pok;
    @(negedge clk);
    check_all();
    cfg_count_mode = mode; push = p; pop_cnt_vld = cv;
    pop_cnt = (IDX_W+1)'(c); flag_clr = f;
    req = mode ? (cv ? c : 0) : (f ? 1 : 0);
    rem = (req > m_fill) ? m_fill : req;
    pok = p && (m_fill != m_depth);
    m_ovf  = p && (m_fill == m_depth);
    m_rd   = (m_rd + rem) % m_depth;
    m_wr   = (m_wr + int'(pok)) % m_depth;
    m_fill = m_fill - rem + int'(pok);
  endtask

  task automatic do_reset(int s, int d);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_start = IDX_W'(s); cfg_depth = (IDX_W+1)'(d);
    cfg_count_mode = 1'b1; push = 0; pop_cnt_vld = 0; pop_cnt = '0; flag_clr = 0;
    m_start = s; m_depth = d; m_fill = 0; m_rd = 0; m_wr = 0; m_ovf = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic random_run(int n);
    for (int i = 0; i < n; i++) begin
      bit md = ($urandom_range(0, 3) != 0) ? 1'b1 : 1'b0;
      cyc(md, $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0,
          $urandom_range(0, m_depth + 2), $urandom_range(0, 2) == 0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    do_reset(5, 10);
    tag = "R1";  cyc(1, 0, 0, 0, 0);
    tag = "R8";  for (int i = 0; i < 10; i++) cyc(1, 1, 0, 0, 0);
    tag = "R10"; cyc(1, 1, 0, 0, 0); cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0);
    tag = "R2";  cyc(1, 0, 1, 3, 0); cyc(1, 0, 1, 0, 0); cyc(1, 0, 0, 0, 0);
    tag = "R7";  cyc(1, 0, 0, 0, 1); cyc(0, 0, 1, 4, 0); cyc(0, 0, 0, 0, 0);
    tag = "R5";  cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0);
    tag = "R4";  for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 0);
                 cyc(1, 0, 1, 6, 0); cyc(1, 0, 1, 3, 0); cyc(1, 0, 0, 0, 0);
    tag = "R9";  cyc(1, 1, 1, 2, 0); cyc(0, 1, 0, 0, 1);
                 for (int i = 0; i < 12; i++) cyc(1, 1, 0, 0, 0);
                 cyc(1, 1, 1, 1, 0); cyc(1, 0, 0, 0, 0);
    tag = "R3";  cyc(1, 0, 1, 31, 0); cyc(1, 0, 0, 0, 0);
    tag = "R6";  cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0);
    tag = "R11"; random_run(1500);
    do_reset(20, 12);
    tag = "R1";  cyc(1, 0, 0, 0, 0);
    tag = "R4";  random_run(1500);
    do_reset(0, 32);
    tag = "R1";  cyc(1, 0, 0, 0, 0);
    tag = "R9";  random_run(1500);
    cyc(1, 0, 0, 0, 0);
    @(negedge clk);
    check_all();
    finish_run();
  end
endmodule